// File: doc/BRIEF.md
# Aliased Single/Double Floating-Point Register File

This block is the storage for a floating-point unit. It holds thirty-two 32-bit registers. The same storage can also be seen as sixteen 64-bit registers. A 64-bit register is named by an even index and covers that register and the odd register after it. In a 64-bit access, the even register supplies the upper 32 bits. A write at one width is therefore visible at the other width without any copying.

There are two combinational read ports and one clocked write port. Each port has its own width select. A double-width access with an odd index is illegal: the block flags it and it has no effect on storage. The block also holds a one-bit condition flag. A compare unit loads it, and branch logic reads it. The block performs no arithmetic.

Top module: `fpreg_alias_file`

## Requirements
- R1: While `rst_n` is low and after its release, every register reads as zero at both widths and `cond_flag` is 0.
- R2: A single-width write (`wr_dbl`=0) stores `wr_data[31:0]` at `wr_idx`. A single-width read (`*_dbl`=0) returns that register in bits 31:0, with bits 63:32 zero.
- R3: A double-width read with an even index 2k returns register 2k in bits 63:32 and register 2k+1 in bits 31:0.
- R4: A double-width write with an even index 2k stores `wr_data[63:32]` in register 2k and `wr_data[31:0]` in register 2k+1.
- R5: A single-width write changes only its own register. The other half of its pair, and every other register, keep their values.
- R6: A single-width write ignores `wr_data[63:32]`.
- R7: A double-width access with an odd index raises that port's error output (`rd_a_bad`, `rd_b_bad` or `wr_bad`) in the same cycle. The read data of that port is all zeros, and such a write changes no register.
- R8: Writes take effect at the rising clock edge. A read of a register being written in the same cycle returns the old value, and the new value appears after the edge.
- R9: The two read ports are independent. Each returns its own index and width in the same cycle.
- R10: When `cmp_valid` is 1, `cond_flag` takes `cmp_result` at the clock edge. Otherwise `cond_flag` holds its value.
- R11: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_dbl | input | 1 | Read port A width: 0 single, 1 double |
| rd_a_data | output | 64 | Read port A data |
| rd_a_bad | output | 1 | Read port A odd double index |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_dbl | input | 1 | Read port B width: 0 single, 1 double |
| rd_b_data | output | 64 | Read port B data |
| rd_b_bad | output | 1 | Read port B odd double index |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_dbl | input | 1 | Write width: 0 single, 1 double |
| wr_data | input | 64 | Write data (single width uses bits 31:0) |
| wr_bad | output | 1 | Write odd double index, write dropped |
| cmp_valid | input | 1 | Compare result valid |
| cmp_result | input | 1 | Compare outcome to store |
| cond_flag | output | 1 | Stored condition flag |

## Verification
Two events often fall in the same cycle.

The first is a write to a register together with a read of that same storage. The read may be at the other width, for example a single write to one half of a pair while a port reads the whole pair. To provoke this, the random phase draws indices from a narrow range, so that writes and reads often land on the same register or pair. A directed step also writes to the register being read. The bench samples the read outputs just before the edge and expects the old contents. It then samples again after the edge and expects the merged new contents from its own model.

The second is a compare update that arrives while a write is in progress. The bench judges this by checking the flag and the storage separately against the model in the same cycle.

// File: rtl/fpreg_pkg.sv
package fpreg_pkg;

  typedef enum logic {
    PREC_SINGLE = 1'b0,
    PREC_DOUBLE = 1'b1
  } prec_e;

  // A double access must name the even half of a pair.
  function automatic logic pair_illegal(input logic dbl, input logic idx_lsb);
    return (dbl == PREC_DOUBLE) && idx_lsb;
  endfunction

endpackage

// File: rtl/fpreg_storage.sv
module fpreg_storage
  import fpreg_pkg::*;
#(
  parameter  int NREG = 32,
  parameter  int WORD = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic                 wr_dbl,
  input  logic [2*WORD-1:0]    wr_data,
  output logic [NREG*WORD-1:0] regs_flat
);

  logic legal_wr;
  assign legal_wr = wr_en && !pair_illegal(wr_dbl, wr_idx[0]);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic            hit_single;
    logic            hit_double;
    logic            ld_en;
    logic [WORD-1:0] half_data;
    logic [WORD-1:0] word_d;
    logic [WORD-1:0] word_q;

    assign hit_single = legal_wr && (wr_dbl == PREC_SINGLE) && (wr_idx == IDXW'(k));
    assign hit_double = legal_wr && (wr_dbl == PREC_DOUBLE) &&
                        (wr_idx[IDXW-1:1] == (IDXW-1)'(k / 2));
    assign ld_en      = hit_single || hit_double;

    // Even register of a pair holds the upper half of a double value.
    if ((k % 2) == 0) begin : g_even
      assign half_data = wr_data[2*WORD-1:WORD];
    end else begin : g_odd
      assign half_data = wr_data[WORD-1:0];
    end

    always_comb begin
      word_d = word_q;
      if (hit_single) begin
        word_d = wr_data[WORD-1:0];
      end else if (hit_double) begin
        word_d = half_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (ld_en) begin
        word_q <= word_d;
      end
    end

    assign regs_flat[k*WORD +: WORD] = word_q;
  end

endmodule

// File: rtl/fpreg_read_port.sv
module fpreg_read_port
  import fpreg_pkg::*;
#(
  parameter  int NREG = 32,
  parameter  int WORD = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG*WORD-1:0] regs_flat,
  input  logic [IDXW-1:0]      idx,
  input  logic                 dbl,
  output logic [2*WORD-1:0]    data,
  output logic                 bad
);

  logic [WORD-1:0] words [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign words[k] = regs_flat[k*WORD +: WORD];
  end

  logic [IDXW-1:0] even_idx;
  logic [IDXW-1:0] odd_idx;
  assign even_idx = {idx[IDXW-1:1], 1'b0};
  assign odd_idx  = {idx[IDXW-1:1], 1'b1};

  always_comb begin
    bad  = pair_illegal(dbl, idx[0]);
    data = '0;
    if (dbl == PREC_SINGLE) begin
      data[WORD-1:0] = words[idx];
    end else if (!bad) begin
      data = {words[even_idx], words[odd_idx]};
    end
  end

endmodule

// File: rtl/fpreg_cond_flag.sv
module fpreg_cond_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid,
  input  logic cmp_result,
  output logic flag
);

  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (cmp_valid) begin
      flag_d = cmp_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (cmp_valid) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/fpreg_alias_file.sv
module fpreg_alias_file
  import fpreg_pkg::*;
#(
  parameter  int NREG = 32,
  parameter  int WORD = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDXW-1:0]   rd_a_idx,
  input  logic              rd_a_dbl,
  output logic [2*WORD-1:0] rd_a_data,
  output logic              rd_a_bad,
  input  logic [IDXW-1:0]   rd_b_idx,
  input  logic              rd_b_dbl,
  output logic [2*WORD-1:0] rd_b_data,
  output logic              rd_b_bad,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic              wr_dbl,
  input  logic [2*WORD-1:0] wr_data,
  output logic              wr_bad,
  input  logic              cmp_valid,
  input  logic              cmp_result,
  output logic              cond_flag
);

  logic [NREG*WORD-1:0] regs_flat;

  fpreg_storage #(.NREG(NREG), .WORD(WORD)) u_storage (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_dbl    (wr_dbl),
    .wr_data   (wr_data),
    .regs_flat (regs_flat)
  );

  fpreg_read_port #(.NREG(NREG), .WORD(WORD)) u_rd_a (
    .regs_flat (regs_flat),
    .idx       (rd_a_idx),
    .dbl       (rd_a_dbl),
    .data      (rd_a_data),
    .bad       (rd_a_bad)
  );

  fpreg_read_port #(.NREG(NREG), .WORD(WORD)) u_rd_b (
    .regs_flat (regs_flat),
    .idx       (rd_b_idx),
    .dbl       (rd_b_dbl),
    .data      (rd_b_data),
    .bad       (rd_b_bad)
  );

  assign wr_bad = wr_en && pair_illegal(wr_dbl, wr_idx[0]);

  fpreg_cond_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_result (cmp_result),
    .flag       (cond_flag)
  );

endmodule

// File: rtl/fpreg_alias_chk.sv
module fpreg_alias_chk #(
  parameter  int NREG = 32,
  parameter  int WORD = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDXW-1:0]   rd_a_idx,
  input logic              rd_a_dbl,
  input logic [2*WORD-1:0] rd_a_data,
  input logic              rd_a_bad,
  input logic [IDXW-1:0]   rd_b_idx,
  input logic              rd_b_dbl,
  input logic [2*WORD-1:0] rd_b_data,
  input logic              rd_b_bad,
  input logic              wr_en,
  input logic [IDXW-1:0]   wr_idx,
  input logic              wr_dbl,
  input logic [2*WORD-1:0] wr_data,
  input logic              wr_bad,
  input logic              cmp_valid,
  input logic              cmp_result,
  input logic              cond_flag
);

  a_r7_bad_read_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_bad |-> (rd_a_data == '0));

  a_r7_bad_read_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_bad |-> (rd_b_data == '0));

  a_r7_odd_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dbl && wr_idx[0]) |=>
      (!$stable(rd_a_idx) || !$stable(rd_a_dbl) || $stable(rd_a_data)));

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(rd_b_idx) || !$stable(rd_b_dbl) || $stable(rd_b_data)));

  a_r4_double_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dbl && !wr_idx[0] && rd_a_dbl && (rd_a_idx == wr_idx)) |=>
      (!$stable(rd_a_idx) || !rd_a_dbl || (rd_a_data == $past(wr_data))));

  a_r10_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (cond_flag == $past(cmp_result)));

  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(cond_flag));

endmodule

bind fpreg_alias_file fpreg_alias_chk #(.NREG(NREG), .WORD(WORD)) u_chk (.*);

// File: tb/fpreg_alias_file_bench.sv
module fpreg_alias_file_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int WORD = 32;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic        rd_a_dbl, rd_b_dbl, wr_dbl;
  logic [63:0] rd_a_data, rd_b_data, wr_data;
  logic        rd_a_bad, rd_b_bad, wr_bad;
  logic        wr_en, cmp_valid, cmp_result, cond_flag;

  fpreg_alias_file #(.NREG(NREG), .WORD(WORD)) u_fpreg_alias_file (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mdl [NREG];
  logic        mdl_flag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] exp_rd(input logic [4:0] idx, input logic dbl);
    if (!dbl) return {32'h0, mdl[idx]};
    if (idx[0]) return 64'h0;
    return {mdl[idx], mdl[{idx[4:1], 1'b1}]};
  endfunction

  function automatic logic exp_bad(input logic [4:0] idx, input logic dbl);
    return dbl && idx[0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " R9 port A data"}, rd_a_data, exp_rd(rd_a_idx, rd_a_dbl));
    chk({req, " R9 port B data"}, rd_b_data, exp_rd(rd_b_idx, rd_b_dbl));
    chk({req, " R7 port A bad"}, 64'(rd_a_bad), 64'(exp_bad(rd_a_idx, rd_a_dbl)));
    chk({req, " R7 port B bad"}, 64'(rd_b_bad), 64'(exp_bad(rd_b_idx, rd_b_dbl)));
    chk({req, " R7 write bad"}, 64'(wr_bad), 64'(wr_en && exp_bad(wr_idx, wr_dbl)));
    chk({req, " R10 flag"}, 64'(cond_flag), 64'(mdl_flag));
  endtask

  task automatic model_edge();
    if (wr_en && !(wr_dbl && wr_idx[0])) begin
      if (wr_dbl) begin
        mdl[wr_idx]                = wr_data[63:32];
        mdl[{wr_idx[4:1], 1'b1}]   = wr_data[31:0];
      end else begin
        mdl[wr_idx] = wr_data[31:0];
      end
    end
    if (cmp_valid) mdl_flag = cmp_result;
  endtask

  // Inputs already driven at the falling edge; check before and after the rising edge.
  task automatic step(input string req);
    #1;
    check_outputs({req, " pre-edge"});
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_dbl = 0; wr_idx = 0; wr_data = 0;
    cmp_valid = 0; cmp_result = 0;
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240917);
    rd_a_idx = 0; rd_a_dbl = 0; rd_b_idx = 0; rd_b_dbl = 0;
    idle_inputs();
    for (int i = 0; i < NREG; i++) mdl[i] = 32'h0;
    mdl_flag = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_outputs("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all registers zero after reset, at both widths
    for (int i = 0; i < NREG; i += 2) begin
      rd_a_idx = 5'(i); rd_a_dbl = 1; rd_b_idx = 5'(i + 1); rd_b_dbl = 0;
      #1;
      chk("R1 double zero", rd_a_data, 64'h0);
      chk("R1 single zero", rd_b_data, 64'h0);
      @(negedge clk);
    end
    chk("R1 flag zero", 64'(cond_flag), 64'h0);

    // R2/R6: single write, upper data ignored
    wr_en = 1; wr_dbl = 0; wr_idx = 5; wr_data = 64'hDEAD_BEEF_1234_5678;
    rd_a_idx = 5; rd_a_dbl = 0; rd_b_idx = 4; rd_b_dbl = 1;
    step("R8 old value");
    idle_inputs();
    #1;
    chk("R2 single read", rd_a_data, 64'h0000_0000_1234_5678);
    chk("R6 upper ignored, R3 pair", rd_b_data, 64'h0000_0000_1234_5678);

    // R4: double write to pair 6/7, then single reads
    wr_en = 1; wr_dbl = 1; wr_idx = 6; wr_data = 64'hAAAA_0001_BBBB_0002;
    rd_a_idx = 6; rd_a_dbl = 1;
    step("R8 double old");
    idle_inputs();
    rd_a_idx = 6; rd_a_dbl = 0; rd_b_idx = 7; rd_b_dbl = 0;
    #1;
    chk("R4 even gets upper", rd_a_data, 64'h0000_0000_AAAA_0001);
    chk("R4 odd gets lower", rd_b_data, 64'h0000_0000_BBBB_0002);

    // R5: single write to odd half changes only that half
    @(negedge clk);
    wr_en = 1; wr_dbl = 0; wr_idx = 7; wr_data = 64'h1111_1111_CAFE_F00D;
    rd_a_idx = 6; rd_a_dbl = 1;
    step("R5 setup");
    idle_inputs();
    #1;
    chk("R5 only odd half changed", rd_a_data, 64'hAAAA_0001_CAFE_F00D);

    // R7: odd double write dropped, odd double reads zero
    @(negedge clk);
    wr_en = 1; wr_dbl = 1; wr_idx = 7; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    rd_a_idx = 7; rd_a_dbl = 1; rd_b_idx = 6; rd_b_dbl = 1;
    #1;
    chk("R7 write bad raised", 64'(wr_bad), 64'h1);
    chk("R7 odd read zero", rd_a_data, 64'h0);
    chk("R7 odd read bad", 64'(rd_a_bad), 64'h1);
    step("R7 odd write");
    idle_inputs();
    #1;
    chk("R7 pair untouched", rd_b_data, 64'hAAAA_0001_CAFE_F00D);

    // R11: wr_en low ignores write data
    @(negedge clk);
    wr_en = 0; wr_dbl = 1; wr_idx = 6; wr_data = 64'h5555_5555_5555_5555;
    step("R11 disabled write");
    #1;
    chk("R11 no change", rd_b_data, 64'hAAAA_0001_CAFE_F00D);
    idle_inputs();

    // R10: flag load and hold
    @(negedge clk);
    cmp_valid = 1; cmp_result = 1;
    step("R10 load one");
    cmp_valid = 0; cmp_result = 0;
    step("R10 hold");
    #1;
    chk("R10 held one", 64'(cond_flag), 64'h1);

    // Random phase with narrow indices to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic narrow;
      narrow     = ($urandom_range(0, 3) != 0);
      wr_en      = ($urandom_range(0, 3) != 0);
      wr_dbl     = 1'($urandom_range(0, 1));
      wr_idx     = narrow ? 5'($urandom_range(0, 5)) : 5'($urandom_range(0, 31));
      wr_data    = {$urandom, $urandom};
      rd_a_idx   = narrow ? 5'($urandom_range(0, 5)) : 5'($urandom_range(0, 31));
      rd_a_dbl   = 1'($urandom_range(0, 1));
      rd_b_idx   = narrow ? 5'($urandom_range(0, 5)) : 5'($urandom_range(0, 31));
      rd_b_dbl   = 1'($urandom_range(0, 1));
      cmp_valid  = 1'($urandom_range(0, 1));
      cmp_result = 1'($urandom_range(0, 1));
      step("R2 R3 R4 R5 R8 random");
    end
    idle_inputs();
    #1;
    check_outputs("R8 final");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule